// File: doc/BRIEF.md
# Three-Phase CCD Horizontal Readout Sequencer

This block produces the per-line horizontal timing for a frame-transfer CCD whose columns are shared among three serial registers, each carrying every third column. It waits in blanking for a line-start strobe. It then fires a fixed burst on the antiblooming gate and a transfer-gate pulse that moves one stored line into the serial registers. After that it clocks the three serial gates one third of a pixel period apart, with a clamp strobe and a sample strobe for each output channel. When the last element has been shifted out it returns to blanking and advances its line counter.

The controller has four named states. `ST_BLANK` waits for the strobe and goes to `ST_ABURST` on `line_start`. `ST_ABURST` emits `AB_PULSES` pulses and goes to `ST_XFER` after the last one. `ST_XFER` holds the transfer gate for `TG_LEN` cycles and then goes to `ST_SHIFT`. `ST_SHIFT` runs one three-slot pixel period per serial element and goes back to `ST_BLANK` on the final slot of the final element.

Each serial element is first a dummy element, then an image pixel, then a dark-reference pixel. A region code and a dark-column flag report which kind is on the outputs, and a line index with a dark-line flag lets downstream black-level logic pick its reference rows.

Top module: `ccd_hreadout_seq`

## Requirements
- R1: After reset, `tg`, `abg`, `srg`, `clamp`, `sample`, `region`, `dark_col` and `line_num` are all zero.
- R2: One cycle after `line_start` is sampled high in blanking, `abg` runs `AB_PULSES` pulses, each `AB_WIDTH` cycles high followed by `AB_WIDTH` cycles low. No other gate is active during the burst.
- R3: `tg` is high for exactly `TG_LEN` cycles, starting in the cycle after the burst's last low cycle. It never overlaps `abg` or any serial clock, and serial clocking begins in the cycle after `tg` falls.
- R4: During readout, the slot counter `p` runs 0, 1, 2 and repeats. `srg[c]` is high only in slot `p == c`, so `srg[1]` follows `srg[0]` by one slot and `srg[2]` follows `srg[1]` by one slot. At most one serial clock is high in any cycle.
- R5: In slot `p`, channel `c` has `clamp[c]` high when `p == (c+1) mod 3` and `sample[c]` high when `p == (c+2) mod 3`.
- R6: `region` encodes the current serial element `e` (0-based, one per pixel period) as follows: 1 for `e < DUMMY_N`, 2 for the following `IMAGE_N` elements, 3 for the last `DARK_N` elements, and 0 outside readout.
- R7: `dark_col` is high exactly while `region` equals 3.
- R8: `line_num` advances by one at the end of each readout and wraps from `LINES-1` to 0. `dark_line` is high when `line_num >= LINES - DARK_LINES`.
- R9: `line_start` has no effect outside `ST_BLANK`, and this includes the final readout slot.
- R10: `srg`, `clamp` and `sample` are all zero during blanking, the burst and the transfer pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Strobe that starts one line sequence |
| tg | output | 1 | Transfer-gate pulse |
| abg | output | 1 | Antiblooming gate burst |
| srg | output | 3 | Serial-register gate clocks, one per channel |
| clamp | output | 3 | Per-channel clamp strobe |
| sample | output | 3 | Per-channel sample strobe |
| region | output | 2 | Element kind: 0 none, 1 dummy, 2 image, 3 dark |
| dark_col | output | 1 | Dark-reference column flag |
| line_num | output | LW | Current line index |
| dark_line | output | 1 | Current line is a dark line |

## Verification
The collision that matters is the end of readout meeting a new line strobe. On the final slot of the last element, the state returns to blanking and the line counter advances in the same edge, and a `line_start` present in that same cycle must be dropped. The bench holds `line_start` high through whole lines, including that last slot, and then requires idle outputs in the following cycle. On other lines it issues the strobe in the very first blanking cycle and requires the burst to start one cycle later. Every cycle is compared with an offset-based model, and `line_num` and `dark_line` are compared across a frame wrap.

// File: rtl/ccd_hseq_pkg.sv
package ccd_hseq_pkg;
    typedef enum logic [1:0] {
        ST_BLANK  = 2'd0,
        ST_ABURST = 2'd1,
        ST_XFER   = 2'd2,
        ST_SHIFT  = 2'd3
    } hstate_t;

    typedef enum logic [1:0] {
        RGN_NONE  = 2'd0,
        RGN_DUMMY = 2'd1,
        RGN_IMAGE = 2'd2,
        RGN_DARK  = 2'd3
    } region_t;
endpackage

// File: rtl/ccd_slot_decode.sv
module ccd_slot_decode (
    input  logic       en,
    input  logic [1:0] slot,
    output logic [2:0] srg,
    output logic [2:0] clamp,
    output logic [2:0] sample
);
    for (genvar c = 0; c < 3; c++) begin : g_ch
        assign srg[c]    = en && (slot == 2'(c));
        assign clamp[c]  = en && (slot == 2'((c + 1) % 3));
        assign sample[c] = en && (slot == 2'((c + 2) % 3));
    end
endmodule

// File: rtl/ccd_line_ctr.sv
module ccd_line_ctr #(
    parameter int LINES      = 488,
    parameter int DARK_LINES = 2,
    parameter int LW         = $clog2(LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [LW-1:0] line_num,
    output logic          dark_line
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_num <= '0;
        else if (adv)
            line_num <= (line_num == LW'(LINES - 1)) ? '0 : line_num + 1'b1;
    end

    assign dark_line = (line_num >= LW'(LINES - DARK_LINES));
endmodule

// File: rtl/ccd_hreadout_seq.sv
module ccd_hreadout_seq
    import ccd_hseq_pkg::*;
#(
    parameter int DUMMY_N    = 12,
    parameter int IMAGE_N    = 378,
    parameter int DARK_N     = 8,
    parameter int LINES      = 488,
    parameter int DARK_LINES = 2,
    parameter int AB_PULSES  = 4,
    parameter int AB_WIDTH   = 2,
    parameter int TG_LEN     = 6,
    localparam int LW        = $clog2(LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    output logic          tg,
    output logic          abg,
    output logic [2:0]    srg,
    output logic [2:0]    clamp,
    output logic [2:0]    sample,
    output logic [1:0]    region,
    output logic          dark_col,
    output logic [LW-1:0] line_num,
    output logic          dark_line
);
    localparam int ELEM_N = DUMMY_N + IMAGE_N + DARK_N;
    localparam int EW     = $clog2(ELEM_N);
    localparam int AB_PER = 2 * AB_WIDTH;
    localparam int CMAX   = (AB_PER > TG_LEN) ? AB_PER : TG_LEN;
    localparam int CW     = $clog2(CMAX + 1);
    localparam int PW     = $clog2(AB_PULSES + 1);

    hstate_t       st, st_n;
    logic [CW-1:0] cnt, cnt_n;
    logic [PW-1:0] pul, pul_n;
    logic [1:0]    ph, ph_n;
    logic [EW-1:0] el, el_n;
    logic          line_done;
    region_t       rgn;

    // next-state and counter logic
    always_comb begin
        st_n      = st;
        cnt_n     = cnt;
        pul_n     = pul;
        ph_n      = ph;
        el_n      = el;
        line_done = 1'b0;
        unique case (st)
            ST_BLANK: begin
                if (line_start) begin
                    st_n  = ST_ABURST;
                    cnt_n = '0;
                    pul_n = '0;
                end
            end
            ST_ABURST: begin
                if (cnt == CW'(AB_PER - 1)) begin
                    cnt_n = '0;
                    if (pul == PW'(AB_PULSES - 1))
                        st_n = ST_XFER;
                    else
                        pul_n = pul + 1'b1;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            ST_XFER: begin
                if (cnt == CW'(TG_LEN - 1)) begin
                    st_n  = ST_SHIFT;
                    cnt_n = '0;
                    ph_n  = 2'd0;
                    el_n  = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            ST_SHIFT: begin
                if (ph == 2'd2) begin
                    ph_n = 2'd0;
                    if (el == EW'(ELEM_N - 1)) begin
                        st_n      = ST_BLANK;
                        line_done = 1'b1;
                    end else begin
                        el_n = el + 1'b1;
                    end
                end else begin
                    ph_n = ph + 1'b1;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_BLANK;
            cnt <= '0;
            pul <= '0;
            ph  <= 2'd0;
            el  <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            pul <= pul_n;
            ph  <= ph_n;
            el  <= el_n;
        end
    end

    // outputs decoded from the registered state
    always_comb begin
        tg  = 1'b0;
        abg = 1'b0;
        rgn = RGN_NONE;
        unique case (st)
            ST_BLANK:  ;
            ST_ABURST: abg = (cnt < CW'(AB_WIDTH));
            ST_XFER:   tg = 1'b1;
            ST_SHIFT: begin
                if (el < EW'(DUMMY_N))
                    rgn = RGN_DUMMY;
                else if (el < EW'(DUMMY_N + IMAGE_N))
                    rgn = RGN_IMAGE;
                else
                    rgn = RGN_DARK;
            end
        endcase
        region   = rgn;
        dark_col = (rgn == RGN_DARK);
    end

    ccd_slot_decode u_slot (
        .en     (st == ST_SHIFT),
        .slot   (ph),
        .srg    (srg),
        .clamp  (clamp),
        .sample (sample)
    );

    ccd_line_ctr #(
        .LINES      (LINES),
        .DARK_LINES (DARK_LINES),
        .LW         (LW)
    ) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (line_done),
        .line_num  (line_num),
        .dark_line (dark_line)
    );
endmodule

// File: rtl/ccd_hseq_checker.sv
module ccd_hseq_checker #(
    parameter int LW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tg,
    input logic          abg,
    input logic [2:0]    srg,
    input logic [2:0]    clamp,
    input logic [2:0]    sample,
    input logic [1:0]    region,
    input logic          dark_col,
    input logic [LW-1:0] line_num
);
    p_srg_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(srg));

    p_srg_rotate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (srg[0] |=> srg[1]) and (srg[1] |=> srg[2]));

    p_tg_abg_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(tg && abg));

    p_serial_after_tg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tg) |-> srg[0]);

    p_strobe_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        srg[0] |-> (clamp[2] && sample[1] && $countones(clamp) == 1 && $countones(sample) == 1));

    p_quiet_outside_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tg || abg) |-> (srg == 3'b0 && clamp == 3'b0 && sample == 3'b0));

    p_dark_col_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dark_col |-> (region == 2'd3));

    p_line_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_num != $past(line_num)) |-> (line_num == $past(line_num) + 1'b1 || line_num == '0));
endmodule

bind ccd_hreadout_seq ccd_hseq_checker #(.LW(LW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tg       (tg),
    .abg      (abg),
    .srg      (srg),
    .clamp    (clamp),
    .sample   (sample),
    .region   (region),
    .dark_col (dark_col),
    .line_num (line_num)
);

// File: tb/sim_ccd_hreadout_seq.sv
module sim_ccd_hreadout_seq;
    localparam int D  = 2;
    localparam int I  = 4;
    localparam int K  = 2;
    localparam int NL = 5;
    localparam int DL = 2;
    localparam int P  = 2;
    localparam int W  = 1;
    localparam int T  = 3;
    localparam int E  = D + I + K;
    localparam int B  = P * 2 * W;
    localparam int TOTAL = B + T + 3 * E;
    localparam int LW = $clog2(NL);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line_start = 1'b0;
    logic          tg, abg, dark_col, dark_line;
    logic [2:0]    srg, clamp, sample;
    logic [1:0]    region;
    logic [LW-1:0] line_num;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    ccd_hreadout_seq #(
        .DUMMY_N (D), .IMAGE_N (I), .DARK_N (K),
        .LINES (NL), .DARK_LINES (DL),
        .AB_PULSES (P), .AB_WIDTH (W), .TG_LEN (T)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .line_start (line_start),
        .tg (tg), .abg (abg), .srg (srg), .clamp (clamp), .sample (sample),
        .region (region), .dark_col (dark_col),
        .line_num (line_num), .dark_line (dark_line)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_idle(input string req);
        chk(srg == 3'b0 && clamp == 3'b0 && sample == 3'b0 && !tg && !abg && region == 2'd0 && !dark_col,
            req, {tg, abg, srg, clamp, sample, region, dark_col}, 0);
    endtask

    // compare all timing outputs at cycle offset k of a line
    task automatic check_offset(input int k);
        bit sh;
        int j, p, e, rg;
        logic [2:0] es, ec, ea;
        sh = (k >= B + T);
        j  = k - B - T;
        p  = sh ? j % 3 : 0;
        e  = sh ? j / 3 : 0;
        for (int c = 0; c < 3; c++) begin
            es[c] = sh && (p == c);
            ec[c] = sh && (p == (c + 1) % 3);
            ea[c] = sh && (p == (c + 2) % 3);
        end
        rg = !sh ? 0 : (e < D) ? 1 : (e < D + I) ? 2 : 3;
        chk(abg == ((k < B) && ((k % (2 * W)) < W)), "R2 abg", abg, (k < B) && ((k % (2 * W)) < W));
        chk(tg == ((k >= B) && (k < B + T)), "R3 tg", tg, (k >= B) && (k < B + T));
        chk(srg == es, "R4 srg", srg, es);
        chk(clamp == ec && sample == ea, "R5 clamp/sample", {clamp, sample}, {ec, ea});
        if (!sh)
            chk(srg == 3'b0 && clamp == 3'b0 && sample == 3'b0, "R10 quiet", {srg, clamp, sample}, 0);
        chk(region == 2'(rg), "R6 region", region, rg);
        chk(dark_col == (rg == 3), "R7 dark_col", dark_col, rg == 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 reset");
        chk(line_num == '0 && !dark_line, "R1 line_num", line_num, 0);

        for (int ln = 0; ln < 2 * NL + 1; ln++) begin
            bit noisy;
            int gap;
            noisy = (ln % 2 == 1);
            gap   = ln % 3;
            chk(line_num == LW'(ln % NL), "R8 line_num", line_num, ln % NL);
            chk(dark_line == ((ln % NL) >= NL - DL), "R8 dark_line", dark_line, (ln % NL) >= NL - DL);
            line_start = 1'b1;
            @(posedge clk);
            for (int k = 0; k < TOTAL; k++) begin
                @(negedge clk);
                check_offset(k);
                line_start = noisy;
            end
            @(posedge clk);
            @(negedge clk);
            line_start = 1'b0;
            // R9: strobe held through the last readout slot must not restart the line
            if (noisy)
                check_idle("R9 ignored strobe");
            else
                check_idle("R10 blank");
            for (int g = 0; g < gap; g++) begin
                @(posedge clk);
                @(negedge clk);
                check_idle("R10 blank gap");
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule